// File: doc/BRIEF.md
# Parallel SAR Converter Host Sequencer

This block sits in an FPGA and runs an external eight-input, twelve-bit successive-approximation converter that has a parallel result bus. It makes the converter's clock by dividing the system clock, and it walks a round-robin scan over the channels allowed by an enable mask. For each channel it pulses the write strobe with the channel number on the address lines. It then waits for the converter's busy line to rise and runs a chip-select/read cycle that takes in the result.

The read cycle also carries a power command. While the read strobe is low, the two low address lines carry the requested power state, so the converter sees that code when the strobe returns high. Every strobe edge that the converter times against its clock is placed on a known edge of the generated clock. Results leave on a one-cycle valid stream that carries the channel tag. If busy does not come back in time, a watchdog pulses an error and the scan carries on.

All minimum times are given in nanoseconds together with the system clock period. The block turns each one into a cycle count, rounding up.

Top module: `adc_host_seq`

## Requirements
- R1: During reset, adc_cs_n, adc_wr_n and adc_rd_n are high, adc_cclk is low, and res_valid and wd_err are low.
- R2: adc_cclk is high for exactly HALF cycles and low for exactly HALF cycles. HALF is the larger of ceil(CCLK_HALF_NS/SYS_NS) and ceil(RD_GAP_NS/SYS_NS), which is 7 with the default parameters.
- R3: A conversion starts with adc_cs_n and adc_wr_n falling on the same edge on which adc_cclk falls. adc_wr_n rises WR_HOLD = ceil(WR_HOLD_NS/SYS_NS) cycles (2 by default) after the next rise of adc_cclk, so it is low for at least 35 ns. While adc_wr_n is low, adc_addr holds the channel number in plain binary and does not change.
- R4: The read cycle starts only after adc_busy has been seen to rise through a two-flop synchronizer. adc_cs_n and adc_rd_n fall together and stay low for at least RD = ceil(RD_ACCESS_NS/SYS_NS) cycles (3 by default). The data word is sampled RD cycles after the fall.
- R5: adc_cs_n and adc_rd_n return high on the same edge on which adc_cclk rises, so at least HALF cycles (at least 50 ns) pass before the next fall of adc_cclk.
- R6: From the start of the read until the next write, adc_addr[1:0] carries pwr_req sampled when the read starts, and adc_addr[2] is 0. The codes are 00 for stay active, 01 for nap, and 10 or 11 for sleep.
- R7: res_valid is high for one cycle, on the edge that releases adc_rd_n. On that cycle res_data is the word sampled during the read and res_ch is the channel that was converted.
- R8: Each conversion takes the next channel above the previous one that is enabled in ch_mask, wrapping from 7 to 0. After reset the scan starts from the lowest enabled channel.
- R9: While run is low or ch_mask is zero, no new write is started.
- R10: If adc_busy has not risen by the 20th rise of adc_cclk after adc_wr_n returns high, wd_err pulses for one cycle on that edge. No result is issued, and the scan moves on to the following channel.
- R11: After a read or a watchdog error, the next write begins at the first fall of adc_cclk on which run is high and ch_mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables new conversions |
| ch_mask | input | 8 | One enable bit per channel |
| pwr_req | input | 2 | Power state to request at each read release |
| adc_busy | input | 1 | Converter busy line, high when idle |
| adc_data | input | 12 | Converter parallel result bus |
| adc_cclk | output | 1 | Generated conversion clock |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_wr_n | output | 1 | Conversion start strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_addr | output | 3 | Channel number or power code |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 12 | Converted word |
| res_ch | output | 3 | Channel tag of the result |
| wd_err | output | 1 | One-cycle busy-timeout pulse |

## Verification
The assertions rely on three things about the inputs. adc_busy falls only after a write begins and rises at most once per conversion. It never rises while a read is in progress. adc_data is steady for as long as the read strobe is low. The bench converter model meets all three: it pulls busy low when it sees the write strobe fall, raises it after a fixed count of conversion-clock rises, and changes its output word only at that rise, before any read. ch_mask, run and pwr_req are changed only on the cycle that follows a result, so no transaction already in flight sees them change.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_CONV, ST_RD} seq_st_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/adc_cclk_gen.sv
module adc_cclk_gen #(
  parameter int HALF = 7
) (
  input  logic clk,
  input  logic rst,
  output logic cclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = (cnt == CW'(HALF - 1));
  assign rise_evt = wrap && !cclk;
  assign fall_evt = wrap && cclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      cclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      cclk <= ~cclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_ch_scan.sv
module adc_ch_scan #(
  parameter int NCH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCH-1:0]         mask,
  input  logic                   adv,
  output logic [$clog2(NCH)-1:0] pick,
  output logic                   any
);
  localparam int CH_W = $clog2(NCH);

  logic [CH_W-1:0] last;

  assign any = |mask;

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NCH; k++) begin
      logic [CH_W-1:0] idx;
      idx = last + CH_W'(k);
      if (!found && mask[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= CH_W'(NCH - 1);
    else if (adv) last <= pick;
  end

  // R8
  pick_en_chk: assert property (@(posedge clk) disable iff (rst)
    adv |-> mask[pick]);
endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
  import adc_host_pkg::*;
#(
  parameter int NCH          = 8,
  parameter int DW           = 12,
  parameter int SYS_NS       = 10,
  parameter int CCLK_HALF_NS = 70,
  parameter int WR_HOLD_NS   = 20,
  parameter int RD_ACCESS_NS = 30,
  parameter int RD_GAP_NS    = 50,
  parameter int WD_CCLK      = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  logic [NCH-1:0]         ch_mask,
  input  logic [1:0]             pwr_req,
  input  logic                   adc_busy,
  input  logic [DW-1:0]          adc_data,
  output logic                   adc_cclk,
  output logic                   adc_cs_n,
  output logic                   adc_wr_n,
  output logic                   adc_rd_n,
  output logic [$clog2(NCH)-1:0] adc_addr,
  output logic                   res_valid,
  output logic [DW-1:0]          res_data,
  output logic [$clog2(NCH)-1:0] res_ch,
  output logic                   wd_err
);
  localparam int CH_W    = $clog2(NCH);
  localparam int HALF    = imax(cdiv(CCLK_HALF_NS, SYS_NS), cdiv(RD_GAP_NS, SYS_NS));
  localparam int WR_HOLD = imax(1, cdiv(WR_HOLD_NS, SYS_NS));
  localparam int RD_CYC  = imax(1, cdiv(RD_ACCESS_NS, SYS_NS));
  localparam int CNT_W   = $clog2(imax(WR_HOLD, RD_CYC) + 1);
  localparam int WD_W    = $clog2(WD_CCLK + 1);

  seq_st_t         st;
  logic            rise_evt, fall_evt;
  logic [CH_W-1:0] pick, cur_ch;
  logic            any, adv, seen_rise;
  logic [CNT_W-1:0] cnt;
  logic [WD_W-1:0]  wd_cnt;
  logic [DW-1:0]    cap;
  logic [2:0]       bsync;
  logic             busy_edge;

  adc_cclk_gen #(.HALF(HALF)) i_cclk (
    .clk(clk), .rst(rst), .cclk(adc_cclk),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  assign adv = (st == ST_IDLE) && run && any && fall_evt;

  adc_ch_scan #(.NCH(NCH)) i_scan (
    .clk(clk), .rst(rst), .mask(ch_mask), .adv(adv),
    .pick(pick), .any(any)
  );

  always_ff @(posedge clk) begin
    if (rst) bsync <= 3'b111;
    else     bsync <= {bsync[1:0], adc_busy};
  end
  assign busy_edge = bsync[1] && !bsync[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      adc_cs_n  <= 1'b1;
      adc_wr_n  <= 1'b1;
      adc_rd_n  <= 1'b1;
      adc_addr  <= '0;
      cur_ch    <= '0;
      seen_rise <= 1'b0;
      cnt       <= '0;
      wd_cnt    <= '0;
      cap       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_ch    <= '0;
      wd_err    <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      wd_err    <= 1'b0;
      case (st)
        ST_IDLE: if (adv) begin
          adc_cs_n  <= 1'b0;
          adc_wr_n  <= 1'b0;
          adc_addr  <= pick;
          cur_ch    <= pick;
          seen_rise <= 1'b0;
          cnt       <= '0;
          st        <= ST_WR;
        end
        ST_WR: if (!seen_rise) begin
          if (rise_evt) begin
            seen_rise <= 1'b1;
            cnt       <= '0;
          end
        end else if (cnt == CNT_W'(WR_HOLD - 1)) begin
          adc_wr_n <= 1'b1;
          adc_cs_n <= 1'b1;
          wd_cnt   <= '0;
          st       <= ST_CONV;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_CONV: if (busy_edge) begin
          adc_cs_n <= 1'b0;
          adc_rd_n <= 1'b0;
          adc_addr <= {{(CH_W-2){1'b0}}, pwr_req};
          cnt      <= '0;
          st       <= ST_RD;
        end else if (rise_evt) begin
          if (wd_cnt == WD_W'(WD_CCLK - 1)) begin
            wd_err <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            wd_cnt <= wd_cnt + 1'b1;
          end
        end
        ST_RD: if (cnt != CNT_W'(RD_CYC)) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(RD_CYC - 1)) cap <= adc_data;
        end else if (rise_evt) begin
          adc_cs_n  <= 1'b1;
          adc_rd_n  <= 1'b1;
          res_valid <= 1'b1;
          res_data  <= cap;
          res_ch    <= cur_ch;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adc_wr_n && $past(!adc_wr_n)) |-> $stable(adc_addr));
  // R11
  wr_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_wr_n) |-> ($fell(adc_cclk) && $fell(adc_cs_n)));
  // R5
  rd_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_rd_n) |-> ($rose(adc_cclk) && $rose(adc_cs_n)));
  // R7
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($rose(adc_rd_n) && !wd_err));
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!adc_wr_n && !adc_rd_n));
  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    wd_err |-> (adc_cs_n && adc_rd_n && adc_wr_n));
endmodule

// File: tb/test_adc_host_seq.sv
module test_adc_host_seq;
  localparam int CLK_NS = 10;
  localparam int HALF   = 7;
  localparam int WRHOLD = 2;
  localparam int RDMIN  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic [7:0] ch_mask = '0;
  logic [1:0] pwr_req = '0;
  logic adc_busy;
  logic [11:0] adc_data;
  logic adc_cclk, adc_cs_n, adc_wr_n, adc_rd_n;
  logic [2:0] adc_addr;
  logic res_valid, wd_err;
  logic [11:0] res_data;
  logic [2:0] res_ch;

  always #(CLK_NS/2) clk = ~clk;

  adc_host_seq i_adc_host_seq (
    .clk(clk), .rst(rst), .run(run), .ch_mask(ch_mask), .pwr_req(pwr_req),
    .adc_busy(adc_busy), .adc_data(adc_data), .adc_cclk(adc_cclk),
    .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n),
    .adc_addr(adc_addr), .res_valid(res_valid), .res_data(res_data),
    .res_ch(res_ch), .wd_err(wd_err)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model
  bit hang = 0;
  logic m_busy = 1'b1;
  logic [2:0] m_ch = '0;
  logic [11:0] m_word = '0;
  logic [1:0] m_pwr = '0;
  logic m_a2 = 1'b0;
  int m_cnt = 0, m_seq = 0;
  logic p_wr = 1'b1, p_cclk = 1'b0, p_rd = 1'b1;

  assign adc_busy = m_busy;
  assign adc_data = (!adc_cs_n && !adc_rd_n) ? m_word : 12'h000;

  always @(negedge clk) begin
    if (p_wr && !adc_wr_n && !adc_cs_n && !hang) begin
      m_busy <= 1'b0;
      m_cnt  <= 0;
    end
    if (!p_wr && adc_wr_n) m_ch <= adc_addr;
    if (!p_cclk && adc_cclk && !m_busy && adc_wr_n) begin
      if (m_cnt == 11) begin
        m_busy <= 1'b1;
        m_word <= {m_ch, 9'(m_seq)};
        m_seq  <= m_seq + 1;
      end
      m_cnt <= m_cnt + 1;
    end
    if (!p_rd && adc_rd_n) begin
      m_pwr <= adc_addr[1:0];
      m_a2  <= adc_addr[2];
    end
    p_wr <= adc_wr_n; p_cclk <= adc_cclk; p_rd <= adc_rd_n;
  end

  // monitor
  function automatic logic [2:0] next_ch(input logic [2:0] last, input logic [7:0] m);
    for (int k = 1; k <= 8; k++) begin
      logic [2:0] idx;
      idx = last + 3'(k);
      if (m[idx]) return idx;
    end
    return last;
  endfunction

  int cyc = 0, res_cnt = 0, err_cnt = 0, wr_falls = 0;
  int hi_len = 0, lo_len = 0, wr_len = 0, rd_len = 0, since_rise = 0;
  int rises_since_wr = 0, rd_rise_cyc = 0;
  bit gap_pend = 0;
  logic [2:0] b_last = 3'd7;
  logic [2:0] last_res_ch = '0;
  logic q_wr = 1'b1, q_rd = 1'b1, q_cclk = 1'b0;
  logic [2:0] q_addr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (adc_cclk != q_cclk) begin
        if (q_cclk) chk(hi_len == HALF, "R2 high phase", hi_len, HALF);
        else if (lo_len > 0) chk(lo_len == HALF, "R2 low phase", lo_len, HALF);
        hi_len = 0; lo_len = 0;
      end
      if (adc_cclk) hi_len++; else lo_len++;
      if (adc_cclk && !q_cclk) begin since_rise = 0; rises_since_wr++; end
      else since_rise++;
      if (!adc_cclk && q_cclk && gap_pend) begin
        chk(cyc - rd_rise_cyc >= 5, "R5 rd to cclk fall gap", cyc - rd_rise_cyc, 5);
        gap_pend = 0;
      end
      if (q_wr && !adc_wr_n) begin
        logic [2:0] e;
        wr_falls++;
        e = next_ch(b_last, ch_mask);
        chk(adc_addr == e, "R8 channel order", adc_addr, e);
        chk(!adc_cclk && q_cclk, "R11 write on cclk fall", adc_cclk, 0);
        chk(!adc_cs_n, "R3 cs low with write", adc_cs_n, 0);
        b_last = e;
        wr_len = 0;
      end
      if (!adc_wr_n) begin
        wr_len++;
        if (!q_wr) chk(adc_addr == q_addr, "R3 address stable", adc_addr, q_addr);
      end
      if (!q_wr && adc_wr_n) begin
        chk(wr_len >= 4, "R3 write width", wr_len, 4);
        chk(since_rise == WRHOLD, "R3 hold after cclk rise", since_rise, WRHOLD);
        rises_since_wr = 0;
      end
      if (q_rd && !adc_rd_n) begin
        chk(adc_busy, "R4 read after busy", adc_busy, 1);
        chk(!adc_cs_n, "R4 cs with read", adc_cs_n, 0);
        rd_len = 0;
      end
      if (!adc_rd_n) rd_len++;
      if (!q_rd && adc_rd_n) begin
        chk(rd_len >= RDMIN, "R4 read width", rd_len, RDMIN);
        chk(adc_cclk && !q_cclk, "R5 release on cclk rise", adc_cclk, 1);
        chk(adc_cs_n, "R5 cs released", adc_cs_n, 1);
        chk(res_valid, "R7 valid at release", res_valid, 1);
        rd_rise_cyc = cyc; gap_pend = 1;
      end
      if (res_valid) begin
        res_cnt++;
        last_res_ch = res_ch;
        chk(res_ch == m_ch, "R7 result channel", res_ch, m_ch);
        chk(res_data == m_word, "R7 result data", res_data, m_word);
      end
      if (wd_err) begin
        err_cnt++;
        chk(rises_since_wr == 20, "R10 timeout window", rises_since_wr, 20);
        chk(!res_valid, "R10 no result on error", res_valid, 0);
      end
      if (cyc > 150000) begin
        chk(0, "watchdog expired", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
    q_wr = adc_wr_n; q_rd = adc_rd_n; q_cclk = adc_cclk; q_addr = adc_addr;
  end

  task automatic wait_results(input int n, input string req);
    int target = res_cnt + n;
    int t = 0;
    while (res_cnt < target && t < 20000) begin @(negedge clk); t++; end
    chk(res_cnt >= target, req, res_cnt, target);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(adc_cs_n && adc_wr_n && adc_rd_n, "R1 strobes idle", {adc_cs_n, adc_wr_n, adc_rd_n}, 7);
    chk(!adc_cclk, "R1 cclk low", adc_cclk, 0);
    chk(!res_valid && !wd_err, "R1 outputs low", {res_valid, wd_err}, 0);
  endtask

  task automatic t_scan_all;
    ch_mask = 8'hFF; pwr_req = 2'b00; run = 1'b1;
    wait_results(9, "R8 full scan results");
    chk(last_res_ch == 3'd0, "R8 wrap to channel 0", last_res_ch, 0);
    @(negedge clk);
    chk(m_pwr == 2'b00 && !m_a2, "R6 active code", {m_a2, m_pwr}, 0);
  endtask

  task automatic t_stop;
    int f0;
    wait_results(1, "R9 sync result");
    run = 1'b0;
    f0 = wr_falls;
    repeat (1500) @(negedge clk);
    chk(wr_falls == f0, "R9 run low blocks writes", wr_falls - f0, 0);
  endtask

  task automatic t_sparse;
    logic [2:0] seen [4];
    ch_mask = 8'h81; run = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wait_results(1, "R8 sparse result");
      seen[i] = last_res_ch;
    end
    chk(seen[0] == 3'd7 && seen[1] == 3'd0 && seen[2] == 3'd7 && seen[3] == 3'd0,
        "R8 sparse order", {seen[0], seen[1], seen[2], seen[3]}, 12'o7070);
  endtask

  task automatic t_power;
    ch_mask = 8'h10;
    for (int p = 1; p < 4; p++) begin
      pwr_req = 2'(p);
      wait_results(2, "R6 power result");
      @(negedge clk);
      chk(m_pwr == 2'(p) && !m_a2, "R6 power code", {m_a2, m_pwr}, p);
      chk(last_res_ch == 3'd4, "R8 single channel", last_res_ch, 4);
    end
    pwr_req = 2'b00;
  endtask

  task automatic t_mask_zero;
    int f0;
    wait_results(1, "R9 sync result");
    ch_mask = 8'h00;
    f0 = wr_falls;
    repeat (1500) @(negedge clk);
    chk(wr_falls == f0, "R9 empty mask blocks writes", wr_falls - f0, 0);
  endtask

  task automatic t_watchdog;
    int e0, r0, t;
    ch_mask = 8'h06;
    wait_results(1, "R10 sync result");
    hang = 1;
    e0 = err_cnt; r0 = res_cnt; t = 0;
    while (err_cnt == e0 && t < 5000) begin @(negedge clk); t++; end
    hang = 0;
    chk(err_cnt == e0 + 1, "R10 error pulse", err_cnt - e0, 1);
    chk(res_cnt == r0, "R10 no result while hung", res_cnt - r0, 0);
    wait_results(1, "R10 recovery result");
    chk(last_res_ch != 3'd0, "R10 scan continues", last_res_ch, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_scan_all();
    t_stop();
    t_sparse();
    t_power();
    t_mask_zero();
    run = 1'b1;
    t_watchdog();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule